// File: doc/BRIEF.md
# Data-Acquisition Card Bus Register Interface

This block is the bus-facing register logic of a small data-acquisition card on an 8-bit I/O bus with 10-bit addresses. A three-bit strap picks one of six 16-byte windows in the range 0x300 to 0x3AF. Inside its window the block holds a control byte that drives the analog multiplexer channel, a gain code and two pacer enables. It returns a status byte made of the end-of-conversion flag, two timer-output pins and five digital input pins. It also keeps an 8-bit digital output latch. Each write to that latch changes exactly one output.

An external converter is reached through a start/done handshake. Reading the result low byte returns the stored sample and starts a new conversion. Software can therefore read the high byte and then the low byte to collect one sample and trigger the next in the same pass. When the channel or gain changes, a settle timer keeps end-of-conversion low for a parameterised number of cycles while the multiplexer settles.

Top module: `daq_bus_if`

## Requirements
- R1: The window base is 0x300 + 0x20*base_sel for base_sel 0 to 5, and the block answers the 16 addresses from that base. For base_sel 6 or 7 nothing is decoded. A read outside the window returns 0xFF, and a write outside it changes nothing.
- R2: A write to offset 0x0 loads the control byte, which appears on the outputs after the next clock edge. Bit 7 drives pacer_irq_en, bit 6 drives pacer_en, bits 5:4 drive gain_code and bits 3:0 drive mux_chan.
- R3: A read of offset 0x0 returns {tmr2_in, pacer_in, EOC, din[4:0]}, with EOC in bit 5.
- R4: A read of offset 0x8 returns result[7:0] in the same cycle. If no conversion is running, adc_start goes high for one cycle after that clock edge, and EOC reads 0 from then on.
- R5: A read of offset 0x9 returns {4'b0000, result[11:8]}.
- R6: adc_done during a conversion latches adc_result as the stored result and sets EOC after that edge. The stored result then stays unchanged until the next done.
- R7: A read of offset 0x8 while a conversion is running produces no adc_start pulse.
- R8: A write to offset 0x4 sets dout[wdata[2:0]] to wdata[3]. Bits 7:4 are ignored and the other seven outputs keep their values.
- R9: chan_valid is low only when diff_mode is 1 and mux_chan is 8 or higher. mux_chan itself is driven unchanged.
- R10: A control write that changes bits 5:0 makes EOC read 0 for SETTLE_CYCLES clock edges after the write edge. A control write that leaves bits 5:0 unchanged does not restart the timer.
- R11: Inside the window, reads of offsets other than 0x0, 0x8 and 0x9 return 0xFF. Writes to offsets other than 0x0 and 0x4 have no effect.
- R12: Reset clears the control byte, all digital outputs, EOC and the stored result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| base_sel | input | 3 | Strap selecting the address window |
| diff_mode | input | 1 | Strap: 1 = differential inputs (8 channels) |
| io_addr | input | 10 | Bus address |
| io_rd | input | 1 | One-cycle read strobe |
| io_wr | input | 1 | One-cycle write strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational, valid while io_rd is high |
| din | input | 5 | Digital input pins |
| tmr2_in | input | 1 | Timer 2 output state |
| pacer_in | input | 1 | Pacer output state |
| adc_start | output | 1 | One-cycle conversion start pulse |
| adc_done | input | 1 | Converter done pulse |
| adc_result | input | 12 | Converter result, valid with adc_done |
| mux_chan | output | 4 | Analog multiplexer channel |
| gain_code | output | 2 | Gain range code (0..3 = 5, 2, 1, 0.5 V full scale) |
| pacer_en | output | 1 | Pacer enable |
| pacer_irq_en | output | 1 | Pacer interrupt enable |
| chan_valid | output | 1 | Channel is legal for the input mode |
| dout | output | 8 | Digital output latch |

## Verification
Read data is combinational, so the bench samples io_rdata 2 ns after it raises the read strobe, in the same cycle. Control, latch, adc_start and EOC changes are all registered and become visible one edge after the access. The bench therefore checks them at the falling edge that follows the access task. The bench's converter model answers three falling edges after it sees adc_start, so the bench allows enough cycles before it checks EOC. The settle window is tested at its boundary: EOC must still be 0 when one edge remains and must be 1 once the last edge has passed.

// File: rtl/daq_bus_pkg.sv
package daq_bus_pkg;
  localparam int ADDR_W     = 10;
  localparam int DATA_W     = 8;
  localparam int RES_W      = 12;
  localparam int DOUT_N     = 8;
  localparam int DIN_N      = 5;
  localparam int BASE_COUNT = 6;
  localparam logic [ADDR_W-1:0] BASE_ORIGIN = 10'h300;

  localparam logic [3:0] OFS_CTRL   = 4'h0;
  localparam logic [3:0] OFS_DOUT   = 4'h4;
  localparam logic [3:0] OFS_RES_LO = 4'h8;
  localparam logic [3:0] OFS_RES_HI = 4'h9;

  typedef struct packed {
    logic       irq_en;
    logic       pacer_en;
    logic [1:0] gain;
    logic [3:0] chan;
  } ctrl_t;
endpackage

// File: rtl/daq_addr_decode.sv
module daq_addr_decode
  import daq_bus_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [SEL_W-1:0]  base_sel,
  output logic              hit,
  output logic [3:0]        offset
);
  logic [ADDR_W-1:0] base;

  always_comb begin
    base   = BASE_ORIGIN + ADDR_W'({base_sel, 5'b0});
    hit    = (32'(base_sel) < BASE_COUNT) && (io_addr[ADDR_W-1:4] == base[ADDR_W-1:4]);
    offset = io_addr[3:0];
  end
endmodule

// File: rtl/daq_conv_ctrl.sv
module daq_conv_ctrl
  import daq_bus_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic             adc_done,
  input  logic [RES_W-1:0] adc_result,
  output logic             adc_start,
  output logic             eoc,
  output logic [RES_W-1:0] result
);
  logic             busy_q, busy_d;
  logic             eoc_q, eoc_d;
  logic             start_q, start_d;
  logic [RES_W-1:0] res_q, res_d;

  always_comb begin
    start_d = start_req & ~busy_q;
    busy_d  = busy_q;
    eoc_d   = eoc_q;
    res_d   = res_q;
    if (start_d) begin
      busy_d = 1'b1;
      eoc_d  = 1'b0;
    end else if (busy_q && adc_done) begin
      busy_d = 1'b0;
      eoc_d  = 1'b1;
      res_d  = adc_result;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      eoc_q   <= 1'b0;
      start_q <= 1'b0;
      res_q   <= '0;
    end else begin
      busy_q  <= busy_d;
      eoc_q   <= eoc_d;
      start_q <= start_d;
      res_q   <= res_d;
    end
  end

  assign adc_start = start_q;
  assign eoc       = eoc_q;
  assign result    = res_q;

  p_start_clears_eoc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> !eoc_q);
  p_no_start_while_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start_req) |=> !adc_start);
  p_done_sets_eoc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && adc_done) |=> (eoc_q && result == $past(adc_result)));
endmodule

// File: rtl/daq_settle_timer.sv
module daq_settle_timer #(
  parameter int SETTLE_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic settling
);
  localparam int CW = $clog2(SETTLE_CYCLES + 1);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)               cnt_d = CW'(SETTLE_CYCLES);
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign settling = (cnt_q != '0);
endmodule

// File: rtl/daq_dout_latch.sv
module daq_dout_latch
  import daq_bus_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        idx,
  input  logic              level,
  output logic [DOUT_N-1:0] dout
);
  logic [DOUT_N-1:0] q;

  for (genvar i = 0; i < DOUT_N; i++) begin : g_bit
    logic en;
    assign en = wr_en && (idx == 3'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q[i] <= 1'b0;
      else if (en) q[i] <= level;
    end
  end

  assign dout = q;

  p_single_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(dout ^ $past(dout)) <= 1);
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(dout));
endmodule

// File: rtl/daq_bus_if.sv
module daq_bus_if
  import daq_bus_pkg::*;
#(
  parameter int SETTLE_CYCLES = 64,
  parameter int SEL_W         = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  base_sel,
  input  logic              diff_mode,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  input  logic [DIN_N-1:0]  din,
  input  logic              tmr2_in,
  input  logic              pacer_in,
  output logic              adc_start,
  input  logic              adc_done,
  input  logic [RES_W-1:0]  adc_result,
  output logic [3:0]        mux_chan,
  output logic [1:0]        gain_code,
  output logic              pacer_en,
  output logic              pacer_irq_en,
  output logic              chan_valid,
  output logic [DOUT_N-1:0] dout
);
  logic [1:0]       rst_sync;
  logic             rst_n_s;
  logic             hit;
  logic [3:0]       offset;
  logic             ctrl_we, dout_we, start_req, settle_load, settling, eoc;
  ctrl_t            ctrl_q, ctrl_d;
  logic [RES_W-1:0] result;
  logic [DATA_W-1:0] status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  daq_addr_decode #(.SEL_W(SEL_W)) u_dec (
    .io_addr (io_addr),
    .base_sel(base_sel),
    .hit     (hit),
    .offset  (offset)
  );

  always_comb begin
    ctrl_we     = io_wr && hit && (offset == OFS_CTRL);
    dout_we     = io_wr && hit && (offset == OFS_DOUT);
    start_req   = io_rd && hit && (offset == OFS_RES_LO);
    settle_load = ctrl_we && (io_wdata[5:0] != ctrl_q[5:0]);
    ctrl_d      = ctrl_we ? ctrl_t'(io_wdata) : ctrl_q;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) ctrl_q <= '0;
    else          ctrl_q <= ctrl_d;
  end

  daq_conv_ctrl u_conv (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .start_req (start_req),
    .adc_done  (adc_done),
    .adc_result(adc_result),
    .adc_start (adc_start),
    .eoc       (eoc),
    .result    (result)
  );

  daq_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .load    (settle_load),
    .settling(settling)
  );

  daq_dout_latch u_dout (
    .clk  (clk),
    .rst_n(rst_n_s),
    .wr_en(dout_we),
    .idx  (io_wdata[2:0]),
    .level(io_wdata[3]),
    .dout (dout)
  );

  always_comb begin
    status   = {tmr2_in, pacer_in, eoc & ~settling, din};
    io_rdata = 8'hFF;
    if (io_rd && hit) begin
      case (offset)
        OFS_CTRL:   io_rdata = status;
        OFS_RES_LO: io_rdata = result[7:0];
        OFS_RES_HI: io_rdata = {4'b0000, result[11:8]};
        default:    io_rdata = 8'hFF;
      endcase
    end
  end

  assign mux_chan     = ctrl_q.chan;
  assign gain_code    = ctrl_q.gain;
  assign pacer_en     = ctrl_q.pacer_en;
  assign pacer_irq_en = ctrl_q.irq_en;
  assign chan_valid   = ~(diff_mode & ctrl_q.chan[3]);

  always_comb begin
    if (rst_n_s && io_rd && hit && offset == OFS_RES_HI)
      p_high_nibble_r5: assert (io_rdata[7:4] == 4'b0000);
  end

  p_settle_masks_eoc_r10: assert property (@(posedge clk) disable iff (!rst_n_s)
    settle_load |=> !status[5]);
  p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    !ctrl_we |=> $stable({pacer_irq_en, pacer_en, gain_code, mux_chan}));
endmodule

// File: tb/daq_bus_if_tb.sv
module daq_bus_if_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  base_sel;
  logic        diff_mode;
  logic [9:0]  io_addr;
  logic        io_rd, io_wr;
  logic [7:0]  io_wdata, io_rdata;
  logic [4:0]  din;
  logic        tmr2_in, pacer_in;
  logic        adc_start, adc_done;
  logic [11:0] adc_result;
  logic [3:0]  mux_chan;
  logic [1:0]  gain_code;
  logic        pacer_en, pacer_irq_en, chan_valid;
  logic [7:0]  dout;

  localparam int SETTLE = 8;
  localparam int LAT    = 3;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [11:0] next_sample = 12'h000;
  int conv_cnt = 0;

  always #5 clk = ~clk;

  daq_bus_if #(.SETTLE_CYCLES(SETTLE)) u_dut (
    .clk(clk), .rst_n(rst_n), .base_sel(base_sel), .diff_mode(diff_mode),
    .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .din(din), .tmr2_in(tmr2_in), .pacer_in(pacer_in),
    .adc_start(adc_start), .adc_done(adc_done), .adc_result(adc_result),
    .mux_chan(mux_chan), .gain_code(gain_code), .pacer_en(pacer_en),
    .pacer_irq_en(pacer_irq_en), .chan_valid(chan_valid), .dout(dout)
  );

  // converter model: done pulse LAT falling edges after start is seen
  always @(negedge clk) begin
    adc_done = 1'b0;
    if (conv_cnt != 0) begin
      conv_cnt = conv_cnt - 1;
      if (conv_cnt == 0) begin
        adc_done   = 1'b1;
        adc_result = next_sample;
      end
    end
    if (adc_start) conv_cnt = LAT;
  end

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [9:0] a, output logic [7:0] d);
    io_addr = a; io_rd = 1'b1;
    #2 d = io_rdata;
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic wr(input logic [9:0] a, input logic [7:0] v);
    io_addr = a; io_wdata = v; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  function automatic int ctrl_out();
    return int'({pacer_irq_en, pacer_en, gain_code, mux_chan});
  endfunction

  // {is_dout_write, wdata, expected dout or control byte}
  localparam logic [16:0] VEC [9] = '{
    {1'b1, 8'h0B, 8'h08}, {1'b1, 8'h08, 8'h09}, {1'b1, 8'h0F, 8'h89},
    {1'b1, 8'h03, 8'h81}, {1'b1, 8'hF0, 8'h80}, {1'b1, 8'h0E, 8'hC0},
    {1'b0, 8'hA5, 8'hA5}, {1'b0, 8'h5F, 8'h5F}, {1'b0, 8'h00, 8'h00}
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got 0x0 expected 0x1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    rst_n = 1'b0; base_sel = 3'd0; diff_mode = 1'b0; io_addr = '0;
    io_rd = 1'b0; io_wr = 1'b0; io_wdata = '0; din = 5'h15;
    tmr2_in = 1'b1; pacer_in = 1'b0; adc_done = 1'b0; adc_result = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12 reset state
    check("R12 dout", dout, 0);
    check("R12 ctrl", ctrl_out(), 0);
    check("R12 start", adc_start, 0);

    // R8 / R2 vector table
    foreach (VEC[i]) begin
      if (VEC[i][16]) begin
        wr(10'h304, VEC[i][15:8]);
        check("R8 dout", dout, VEC[i][7:0]);
      end else begin
        wr(10'h300, VEC[i][15:8]);
        check("R2 ctrl", ctrl_out(), VEC[i][7:0]);
      end
    end
    repeat (SETTLE + 2) @(negedge clk);

    // R3 status, no conversion yet
    rd(10'h300, d); check("R3 status", d, 8'h95);

    // R4 / R5 / R6 conversion
    next_sample = 12'hABC;
    rd(10'h308, d); check("R12 result lo", d, 8'h00);
    check("R4 start pulse", adc_start, 1);
    rd(10'h300, d); check("R4 eoc cleared", d[5], 0);
    repeat (6) @(negedge clk);
    rd(10'h300, d); check("R6 eoc set", d[5], 1);
    rd(10'h309, d); check("R5 high byte", d, 8'h0A);
    next_sample = 12'h5F1;
    rd(10'h308, d); check("R6 low byte", d, 8'hBC);
    check("R4 retrigger", adc_start, 1);
    rd(10'h308, d); check("R7 no start busy", adc_start, 0);
    repeat (8) @(negedge clk);
    rd(10'h309, d); check("R6 new high", d, 8'h05);
    rd(10'h308, d); check("R6 new low", d, 8'hF1);
    repeat (8) @(negedge clk);

    // R10 settle window
    wr(10'h300, 8'h03);
    rd(10'h300, d); check("R10 masked", d[5], 0);
    repeat (6) @(negedge clk);
    rd(10'h300, d); check("R10 last edge masked", d[5], 0);
    rd(10'h300, d); check("R10 expired", d[5], 1);
    wr(10'h300, 8'h03);
    rd(10'h300, d); check("R10 same value no reload", d[5], 1);

    // R9 channel validity
    diff_mode = 1'b1;
    wr(10'h300, 8'h09); check("R9 diff ch9", chan_valid, 0);
    check("R9 chan passthrough", mux_chan, 9);
    wr(10'h300, 8'h07); check("R9 diff ch7", chan_valid, 1);
    diff_mode = 1'b0;
    wr(10'h300, 8'h09); check("R9 single ch9", chan_valid, 1);
    repeat (SETTLE + 2) @(negedge clk);

    // R1 window selection
    base_sel = 3'd2;
    rd(10'h300, d); check("R1 old base", d, 8'hFF);
    wr(10'h304, 8'h0D); check("R1 write outside", dout, 8'hC0);
    rd(10'h340, d); check("R1 new base status", d[4:0], 5'h15);
    wr(10'h344, 8'h0D); check("R1 write inside", dout, 8'hE0);
    base_sel = 3'd6;
    rd(10'h3C0, d); check("R1 sel6 3C0", d, 8'hFF);
    rd(10'h300, d); check("R1 sel6 300", d, 8'hFF);
    base_sel = 3'd0;

    // R11 undecoded offsets
    rd(10'h304, d); check("R11 rd ofs4", d, 8'hFF);
    rd(10'h30C, d); check("R11 rd ofsC", d, 8'hFF);
    wr(10'h302, 8'hFF);
    check("R11 wr ctrl kept", ctrl_out(), 8'h09);
    check("R11 wr dout kept", dout, 8'hE0);

    // R12 reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    check("R12 dout", dout, 0);
    check("R12 ctrl", ctrl_out(), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd(10'h300, d); check("R12 eoc", d[5], 0);
    rd(10'h309, d); check("R12 result", d, 8'h00);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule